// File: doc/BRIEF.md
# DRAM Address Mapper with Open-Row Tracking

This block turns a stream of physical byte addresses into DRAM coordinates and says how each access would fare against the row buffers. Each accepted address is cut into a byte offset, a column, a channel, a rank, a bank and a row. The bank index is not taken straight from the address. It is the XOR of three address bits with the low three row bits, so that large power-of-two strides spread over several banks instead of piling into one.

Alongside the decoder, a table records the open row of every bank. There are 2 channels × 2 ranks × 8 banks, which gives 32 entries. Each request is graded as a hit on the open row, an activation of an idle bank, or a conflict that replaces the open row. A saturating counter tracks activations. A flag marks a request that falls in the same bank as the previous accepted request but in a different row, which is the access pattern that causes bank thrashing.

The block takes one request per cycle. Its result is registered, so it appears one cycle after the handshake.

Top module: `dram_addr_mapper`

## Requirements
- R1: Address bits [5:0] are the byte offset, bit [6] is the channel, bits [13:7] are the 7-bit column, bit [17] is the rank and bits [32:18] are the 15-bit row. Any address bits above bit 32 have no effect on any output.
- R2: The 3-bit bank equals address bits [16:14] XOR row[2:0]. For example, two addresses 2^18 apart that share bits [16:14] land in different banks.
- R3: `req_ready` is low during reset and high afterwards. `rsp_valid` is high in exactly the cycle after each accepted request (`req_valid` and `req_ready` both high at the clock edge), and the response fields belong to that request.
- R4: `rsp_class` is 0 for a hit (the bank is open on the same row), 1 for an activation of an idle bank, and 2 for a conflict (the bank is open on another row). The value 3 never occurs. State is kept separately for each {channel, rank, bank}.
- R5: Every accepted request leaves its bank open on its own row. A conflict replaces the open row at the same clock edge that registers the result, so a following request to the new row is a hit.
- R6: Reset closes all 32 banks, so the first access to any bank afterwards is class 1. Reset also clears `act_count` and `rsp_valid` to 0.
- R7: `act_count` increases by one for every response of class 1 or 2. It does not change on a hit. It saturates at all ones (width `CNT_W`).
- R8: `cnt_clear` sets `act_count` to 0. When a clear and a counted request meet at the same edge, the result is 1.
- R9: `rsp_sbdr` is 1 when the request has the same channel, rank and bank as the previous accepted request and a different row. It is 0 for the first request after reset and whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high |
| req_addr | input | ADDR_W (40) | Physical byte address |
| cnt_clear | input | 1 | Clear activation counter |
| rsp_valid | output | 1 | Response present |
| rsp_offset | output | 6 | Byte offset in line |
| rsp_column | output | 7 | Column index |
| rsp_channel | output | 1 | Channel |
| rsp_rank | output | 1 | Rank |
| rsp_bank | output | 3 | Hashed bank |
| rsp_row | output | 15 | Row number |
| rsp_class | output | 2 | 0 hit, 1 activate, 2 conflict |
| rsp_sbdr | output | 1 | Same bank, different row as previous request |
| act_count | output | CNT_W (32) | Saturating activation count |

## Verification
Two counter operations can fall on the same edge: an activation or conflict that increments the counter, and the clear input. The bench provokes this by raising `cnt_clear` in the same cycle as a request that conflicts with an open row, and it expects the counter to read exactly 1. A second collision is a conflict on a counter that has already saturated. The bench builds this with a reduced counter width and a run of alternating rows in one bank, and it judges that the count holds at its maximum while the row is still replaced.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

    localparam int OFF_W  = 6;
    localparam int CH_W   = 1;
    localparam int COL_W  = 7;
    localparam int BANK_W = 3;
    localparam int RANK_W = 1;
    localparam int ROW_W  = 15;

    localparam int CH_LSB   = OFF_W;
    localparam int COL_LSB  = CH_LSB + CH_W;
    localparam int BSEL_LSB = COL_LSB + COL_W;
    localparam int RANK_LSB = BSEL_LSB + BANK_W;
    localparam int ROW_LSB  = RANK_LSB + RANK_W;
    localparam int USED_W   = ROW_LSB + ROW_W;

    localparam int IDX_W    = CH_W + RANK_W + BANK_W;
    localparam int N_BANKS  = 1 << IDX_W;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_ACT      = 2'd1,
        CLS_CONFLICT = 2'd2
    } access_cls_e;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [OFF_W-1:0]  off;
    } dram_loc_t;

    function automatic dram_loc_t split_addr(input logic [USED_W-1:0] a);
        dram_loc_t l;
        l.off  = a[CH_LSB-1:0];
        l.ch   = a[COL_LSB-1:CH_LSB];
        l.col  = a[BSEL_LSB-1:COL_LSB];
        l.rank = a[ROW_LSB-1:RANK_LSB];
        l.row  = a[USED_W-1:ROW_LSB];
        l.bank = a[RANK_LSB-1:BSEL_LSB] ^ a[ROW_LSB+BANK_W-1:ROW_LSB];
        return l;
    endfunction

    function automatic logic [IDX_W-1:0] bank_index(input dram_loc_t l);
        return {l.ch, l.rank, l.bank};
    endfunction

endpackage

// File: rtl/addr_splitter.sv
module addr_splitter
    import dram_map_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] addr,
    output dram_loc_t         loc
);
    assign loc = split_addr(addr[USED_W-1:0]);

    generate
        if (ADDR_W > USED_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:USED_W];
        end
    endgenerate
endmodule

// File: rtl/open_row_table.sv
module open_row_table
    import dram_map_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic [ROW_W-1:0]    row,
    output access_cls_e         cls
);
    logic [N_BANKS-1:0] valid_q;
    logic [ROW_W-1:0]   row_q [N_BANKS];

    always_comb begin
        if (!valid_q[idx])
            cls = CLS_ACT;
        else if (row_q[idx] == row)
            cls = CLS_HIT;
        else
            cls = CLS_CONFLICT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            row_q[idx] <= row;
    end

    // R5: the bank just accessed is open on the row just accessed
    a_r5_row_opened: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(idx)] && row_q[$past(idx)] == $past(row)));

    // R4: an access that just opened a row hits it when repeated
    a_r4_repeat_hits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && idx == $past(idx) && row == $past(row) && !$past(rst))
        |-> cls == CLS_HIT);
endmodule

// File: rtl/act_counter.sv
module act_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (clr)
            count <= inc ? ONE : '0;
        else if (inc && count != MAX)
            count <= count + ONE;
    end

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && count != MAX) |=> count == $past(count) + ONE);

    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (!clr && count == MAX) |=> count == MAX);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !inc) |=> count == '0);
endmodule

// File: rtl/sbdr_tracker.sv
module sbdr_tracker
    import dram_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  dram_loc_t loc,
    output logic      sbdr
);
    logic      prev_valid_q;
    dram_loc_t prev_q;

    assign sbdr = prev_valid_q
               && bank_index(prev_q) == bank_index(loc)
               && prev_q.row != loc.row;

    always_ff @(posedge clk) begin
        if (rst)
            prev_valid_q <= 1'b0;
        else if (accept)
            prev_valid_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (accept)
            prev_q <= loc;
    end
endmodule

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper
    import dram_map_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cnt_clear,
    output logic              rsp_valid,
    output logic [5:0]        rsp_offset,
    output logic [6:0]        rsp_column,
    output logic              rsp_channel,
    output logic              rsp_rank,
    output logic [2:0]        rsp_bank,
    output logic [14:0]       rsp_row,
    output logic [1:0]        rsp_class,
    output logic              rsp_sbdr,
    output logic [CNT_W-1:0]  act_count
);
    logic        ready_q;
    logic        accept;
    dram_loc_t   loc;
    access_cls_e cls;
    logic        sbdr_now;

    logic        rsp_valid_q;
    dram_loc_t   loc_q;
    access_cls_e cls_q;
    logic        sbdr_q;

    assign accept = req_valid && ready_q;

    addr_splitter #(.ADDR_W(ADDR_W)) u_split (
        .addr (req_addr),
        .loc  (loc)
    );

    open_row_table u_table (
        .clk   (clk),
        .rst   (rst),
        .wr_en (accept),
        .idx   (bank_index(loc)),
        .row   (loc.row),
        .cls   (cls)
    );

    sbdr_tracker u_sbdr (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .loc    (loc),
        .sbdr   (sbdr_now)
    );

    act_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clear),
        .inc   (accept && cls != CLS_HIT),
        .count (act_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            sbdr_q      <= 1'b0;
            cls_q       <= CLS_HIT;
        end else begin
            ready_q     <= 1'b1;
            rsp_valid_q <= accept;
            sbdr_q      <= accept && sbdr_now;
            if (accept)
                cls_q <= cls;
        end
    end

    always_ff @(posedge clk) begin
        if (accept)
            loc_q <= loc;
    end

    assign req_ready   = ready_q;
    assign rsp_valid   = rsp_valid_q;
    assign rsp_offset  = loc_q.off;
    assign rsp_column  = loc_q.col;
    assign rsp_channel = loc_q.ch;
    assign rsp_rank    = loc_q.rank;
    assign rsp_bank    = loc_q.bank;
    assign rsp_row     = loc_q.row;
    assign rsp_class   = cls_q;
    assign rsp_sbdr    = sbdr_q;

    a_r3_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    a_r4_class_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_class != 2'd3);

    a_r9_sbdr_only_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_sbdr |-> (rsp_valid && rsp_class == 2'd2));
endmodule

// File: tb/tb_dram_addr_mapper.sv
`timescale 1ns/1ps
module tb_dram_addr_mapper;
    localparam int ADDR_W = 40;
    localparam int CNT_W  = 4;
    localparam int NV     = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              cnt_clear = 1'b0;
    logic              rsp_valid;
    logic [5:0]        rsp_offset;
    logic [6:0]        rsp_column;
    logic              rsp_channel;
    logic              rsp_rank;
    logic [2:0]        rsp_bank;
    logic [14:0]       rsp_row;
    logic [1:0]        rsp_class;
    logic              rsp_sbdr;
    logic [CNT_W-1:0]  act_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dram_addr_mapper #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk, .rst, .req_valid, .req_ready, .req_addr, .cnt_clear,
        .rsp_valid, .rsp_offset, .rsp_column, .rsp_channel, .rsp_rank,
        .rsp_bank, .rsp_row, .rsp_class, .rsp_sbdr, .act_count
    );

    // vector: ch, rank, bank, row, col, off, hi7, exp class, exp sbdr
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd0, 15'd100,   7'd5,   6'd3,  7'h00, 2'd1, 1'b0},
        {1'b0, 1'b0, 3'd0, 15'd100,   7'd9,   6'd0,  7'h00, 2'd0, 1'b0},
        {1'b1, 1'b0, 3'd0, 15'd100,   7'd9,   6'd0,  7'h00, 2'd1, 1'b0},
        {1'b0, 1'b0, 3'd0, 15'd200,   7'd0,   6'd0,  7'h00, 2'd2, 1'b0},
        {1'b0, 1'b0, 3'd0, 15'd100,   7'd0,   6'd0,  7'h00, 2'd2, 1'b1},
        {1'b0, 1'b1, 3'd0, 15'd100,   7'd0,   6'd0,  7'h00, 2'd1, 1'b0},
        {1'b0, 1'b1, 3'd0, 15'd100,   7'd1,   6'd1,  7'h7F, 2'd0, 1'b0},
        {1'b0, 1'b0, 3'd3, 15'd7,     7'd0,   6'd0,  7'h00, 2'd1, 1'b0},
        {1'b0, 1'b0, 3'd3, 15'd15,    7'd0,   6'd0,  7'h00, 2'd2, 1'b1},
        {1'b0, 1'b0, 3'd0, 15'd100,   7'd0,   6'd0,  7'h55, 2'd0, 1'b0},
        {1'b1, 1'b1, 3'd7, 15'd32767, 7'd127, 6'd63, 7'h00, 2'd1, 1'b0}
    };

    function automatic logic [ADDR_W-1:0] mk(input logic ch, input logic rk,
            input logic [2:0] bk, input logic [14:0] row, input logic [6:0] col,
            input logic [5:0] off, input logic [6:0] hi);
        return {hi, row, rk, bk ^ row[2:0], col, ch, off};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, accepted at next posedge, result sampled at the following negedge
    task automatic send(input logic [ADDR_W-1:0] a, input logic clr);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        cnt_clear = clr;
        @(negedge clk);
        req_valid = 1'b0;
        cnt_clear = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6 / R3 reset state
        check("R3 ready low in reset", 64'(req_ready), 64'd0);
        check("R6 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R6 count in reset", 64'(act_count), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R3 ready after reset", 64'(req_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            v = VEC[i];
            send(mk(v[42], v[41], v[40:38], v[37:23], v[22:16], v[15:10], v[9:3]), 1'b0);
            check("R3 rsp_valid", 64'(rsp_valid), 64'd1);
            check("R1 offset",  64'(rsp_offset),  64'(v[15:10]));
            check("R1 column",  64'(rsp_column),  64'(v[22:16]));
            check("R1 channel", 64'(rsp_channel), 64'(v[42]));
            check("R1 rank",    64'(rsp_rank),    64'(v[41]));
            check("R1 row",     64'(rsp_row),     64'(v[37:23]));
            check("R2 bank",    64'(rsp_bank),    64'(v[40:38]));
            check("R4 class",   64'(rsp_class),   64'(v[2:1]));
            check("R9 sbdr",    64'(rsp_sbdr),    64'(v[0]));
        end
        check("R7 count after table", 64'(act_count), 64'd8);
        @(negedge clk);
        check("R3 no rsp when idle", 64'(rsp_valid), 64'd0);
        check("R9 sbdr low when idle", 64'(rsp_sbdr), 64'd0);

        // R2: stride of 2^18 with equal bits [16:14] moves to another bank
        send((40'd5 << 14) | (40'd3 << 18), 1'b0);
        check("R2 xor bank A", 64'(rsp_bank), 64'd6);
        send((40'd5 << 14) | (40'd4 << 18), 1'b0);
        check("R2 xor bank B", 64'(rsp_bank), 64'd1);
        check("R9 stride not sbdr", 64'(rsp_sbdr), 64'd0);
        check("R7 count 10", 64'(act_count), 64'd10);

        // R8 clear alone
        @(negedge clk);
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        check("R8 clear alone", 64'(act_count), 64'd0);

        // R8 clear together with a conflict (bank 6 open on row 3)
        send(mk(1'b0, 1'b0, 3'd6, 15'd11, 7'd0, 6'd0, 7'd0), 1'b1);
        check("R8 clear+conflict class", 64'(rsp_class), 64'd2);
        check("R8 clear+conflict count", 64'(act_count), 64'd1);

        // R7 saturation via alternating rows in bank 6
        for (int k = 0; k < 20; k++)
            send(mk(1'b0, 1'b0, 3'd6, (k % 2 == 0) ? 15'd3 : 15'd11, 7'd0, 6'd0, 7'd0), 1'b0);
        check("R7 saturated", 64'(act_count), 64'd15);
        check("R9 sbdr on alternation", 64'(rsp_sbdr), 64'd1);
        send(mk(1'b0, 1'b0, 3'd6, 15'd11, 7'd0, 6'd0, 7'd0), 1'b0);
        check("R5 last conflict row now open", 64'(rsp_class), 64'd0);
        check("R7 hit not counted", 64'(act_count), 64'd15);
        send(mk(1'b0, 1'b0, 3'd6, 15'd3, 7'd0, 6'd0, 7'd0), 1'b0);
        check("R7 conflict at max", 64'(act_count), 64'd15);
        check("R4 conflict at max class", 64'(rsp_class), 64'd2);

        // R6 reset closes banks
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R6 count after reset", 64'(act_count), 64'd0);
        check("R6 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        send(mk(1'b0, 1'b0, 3'd6, 15'd3, 7'd0, 6'd0, 7'd0), 1'b0);
        check("R6 bank empty after reset", 64'(rsp_class), 64'd1);
        check("R9 first after reset", 64'(rsp_sbdr), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule